// File: doc/BRIEF.md
# Edge-Serviced Watchdog Timer

This block supervises a processor's activity by watching a single service line. The processor is expected to change the level of the line, either up or down, at least once inside a selectable watchdog period. If the line stays at one level for the whole period, the block raises a one-cycle expiry request. A reset generator turns that request into a system reset.

The service line is asynchronous. It passes through a two-flop synchronizer and then an edge detector, so every rising and every falling transition counts as one service event. A 2-bit code picks the period as a multiple of a base cycle count, in the ratios 1, 16, 254 and 4063. The reset generator drives a hold input. While hold is high, the counter stays at zero, and counting restarts from zero once hold drops.

A flag marks the service line as floating. While the flag is set, the block produces its own service event each time the count reaches seven eighths of the period. The watchdog can therefore never expire in that condition.

Control is a three-state machine:
- HOLD: hold is asserted and the count is zero.
- RUN: the counter advances.
- FIRE: the single cycle in which the expiry request is high.

The transitions are:
- HOLD to RUN when hold drops.
- RUN to RUN with a cleared count on a service event or a self-service event.
- RUN to FIRE when the count reaches its limit with no event.
- FIRE to RUN after one cycle.
- Any state to HOLD while hold is high.

Top module: `svc_watchdog`

## Requirements
- R1: While `rst_ni` is low, `expire_o` is 0 and the machine is in HOLD with a zero count.
- R2: A rising edge and a falling edge of `svc_i` each clear the count. The edge reaches the counter three clock edges after the new level is first sampled (two synchronizer flops plus an edge register). A level held high or held low does not clear the count.
- R3: Let L be the selected period and let the count be cleared at clock edge E0. With no service event, `expire_o` is high for exactly one cycle, following edge E0+L. The count is zero in that cycle, and a still-unserviced watchdog fires again L+1 edges later.
- R4: While `hold_i` is 1, `expire_o` stays 0 and the count is held at zero. The edge that samples `hold_i` low is the clear edge E0 for R3.
- R5: `period_sel_i` picks L = BASE_CYC times a ratio: code 0 gives 1, code 1 gives 16, code 2 gives 254 and code 3 gives 4063.
- R6: While `svc_float_i` is 1, a self-service event clears the count when it reaches L − L/8 (integer division), and `expire_o` never rises.
- R7: A service event that reaches the counter on the same edge as the expiry threshold wins. The count clears and no pulse is raised.
- R8: A service pulse lasting one clock cycle produces two service events, one for its rising edge and one for its falling edge.
- R9: `expire_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock; its period must be shorter than the shortest service pulse |
| rst_ni | input | 1 | Asynchronous active-low reset |
| svc_i | input | 1 | Asynchronous service line from the processor |
| svc_float_i | input | 1 | 1 when the service line is undriven (self-service enabled) |
| hold_i | input | 1 | 1 while the system reset is asserted; keeps the count at zero |
| period_sel_i | input | 2 | Watchdog period code (R5) |
| expire_o | output | 1 | One-cycle expiry request |

## Verification
A service event and the expiry threshold can fall on the same clock edge. The bench provokes this by toggling the service line two cycles before the threshold. A correct design then fires at 2L+1 cycles after hold drops rather than at L+1. One cycle later the event arrives too late, and the bench expects the pulse at L+1. Hold and expiry can also coincide; that case is judged by sampling hold high mid-count and requiring a quiet output throughout, followed by a full period once hold drops.

// File: rtl/svc_wdg_pkg.sv
package svc_wdg_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wdg_state_e;

    localparam int unsigned RATIO_C0 = 1;
    localparam int unsigned RATIO_C1 = 16;
    localparam int unsigned RATIO_C2 = 254;
    localparam int unsigned RATIO_C3 = 4063;

    function automatic int unsigned period_cycles(input int unsigned base,
                                                  input logic [1:0] code);
        int unsigned r;
        case (code)
            2'd0:    r = RATIO_C0;
            2'd1:    r = RATIO_C1;
            2'd2:    r = RATIO_C2;
            default: r = RATIO_C3;
        endcase
        return base * r;
    endfunction

endpackage

// File: rtl/svc_sync_edge.sv
module svc_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic evt_o
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= 1'b0;
                else         chain_q[g] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) chain_q[g] <= 1'b0;
                else         chain_q[g] <= chain_q[g-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) last_q <= 1'b0;
        else         last_q <= chain_q[STAGES-1];
    end

    assign evt_o = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/svc_wdg_period.sv
module svc_wdg_period
    import svc_wdg_pkg::*;
#(
    parameter int unsigned BASE_CYC = 63,
    parameter int unsigned CNT_W    = 18
) (
    input  logic [1:0]       sel_i,
    output logic [CNT_W-1:0] lim_m1_o,
    output logic [CNT_W-1:0] flt_m1_o
);
    localparam int unsigned NCODES = 4;

    logic [CNT_W-1:0] lim_tab [NCODES];
    logic [CNT_W-1:0] flt_tab [NCODES];

    for (genvar g = 0; g < NCODES; g++) begin : g_code
        localparam int unsigned P = period_cycles(BASE_CYC, 2'(g));
        localparam int unsigned F = P - (P / 8);
        assign lim_tab[g] = CNT_W'(P - 1);
        assign flt_tab[g] = CNT_W'(F - 1);
    end

    assign lim_m1_o = lim_tab[sel_i];
    assign flt_m1_o = flt_tab[sel_i];

endmodule

// File: rtl/svc_wdg_fsm.sv
module svc_wdg_fsm
    import svc_wdg_pkg::*;
#(
    parameter int unsigned CNT_W   = 18,
    parameter int unsigned CNT_MAX = 255
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hold_i,
    input  logic             svc_evt_i,
    input  logic             float_i,
    input  logic [CNT_W-1:0] lim_m1_i,
    input  logic [CNT_W-1:0] flt_m1_i,
    output logic             expire_o
);
    wdg_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             self_evt, any_evt, at_lim;

    assign self_evt = float_i && (cnt_q >= flt_m1_i);
    assign any_evt  = svc_evt_i || self_evt;
    assign at_lim   = (cnt_q >= lim_m1_i);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD: state_d = hold_i ? ST_HOLD : ST_RUN;
            ST_RUN: begin
                if (hold_i)       state_d = ST_HOLD;
                else if (any_evt) state_d = ST_RUN;
                else if (at_lim)  state_d = ST_FIRE;
                else              state_d = ST_RUN;
            end
            ST_FIRE: state_d = hold_i ? ST_HOLD : ST_RUN;
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_HOLD;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (hold_i || state_q != ST_RUN || any_evt || at_lim) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        expire_o = 1'b0;
        unique case (state_q)
            ST_HOLD: expire_o = 1'b0;
            ST_RUN:  expire_o = 1'b0;
            ST_FIRE: expire_o = 1'b1;
            default: expire_o = 1'b0;
        endcase
    end

    p_edge_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (svc_evt_i && !hold_i) |=> (cnt_q == '0 && !expire_o));

    p_fire_cnt_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |-> (cnt_q == '0));

    p_hold_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (!expire_o && cnt_q == '0));

    p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < CNT_W'(CNT_MAX));

    p_float_no_fire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        float_i |=> !expire_o);

    p_fire_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> !expire_o);

endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import svc_wdg_pkg::*;
#(
    parameter int unsigned BASE_CYC    = 63,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       svc_i,
    input  logic       svc_float_i,
    input  logic       hold_i,
    input  logic [1:0] period_sel_i,
    output logic       expire_o
);
    localparam int unsigned LONGEST = period_cycles(BASE_CYC, 2'd3);
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

    logic             svc_evt;
    logic [CNT_W-1:0] lim_m1, flt_m1;

    svc_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (svc_i),
        .evt_o  (svc_evt)
    );

    svc_wdg_period #(.BASE_CYC(BASE_CYC), .CNT_W(CNT_W)) period_i (
        .sel_i    (period_sel_i),
        .lim_m1_o (lim_m1),
        .flt_m1_o (flt_m1)
    );

    svc_wdg_fsm #(.CNT_W(CNT_W), .CNT_MAX(LONGEST)) fsm_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hold_i    (hold_i),
        .svc_evt_i (svc_evt),
        .float_i   (svc_float_i),
        .lim_m1_i  (lim_m1),
        .flt_m1_i  (flt_m1),
        .expire_o  (expire_o)
    );

endmodule

// File: tb/svc_watchdog_tb_top.sv
`timescale 1ns/1ps
module svc_watchdog_tb_top;

    localparam int unsigned BASE = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       svc = 1'b0;
    logic       flt = 1'b0;
    logic       hold = 1'b1;
    logic [1:0] sel = 2'd0;
    logic       expire;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    svc_watchdog #(.BASE_CYC(BASE), .SYNC_STAGES(2)) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .svc_i        (svc),
        .svc_float_i  (flt),
        .hold_i       (hold),
        .period_sel_i (sel),
        .expire_o     (expire)
    );

    function automatic int period_of(input int code);
        int r;
        case (code)
            0: r = 1;
            1: r = 16;
            2: r = 254;
            default: r = 4063;
        endcase
        return BASE * r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rehold(input int code, input logic f);
        @(posedge clk); #1;
        hold = 1'b1; sel = 2'(code); flt = f;
        repeat (6) @(posedge clk);
        #1;
    endtask

    // hold is dropped here; the next posedge is the clear edge.
    // Returns iteration n (sampled after edge E0+n-1) where expire is seen, 0 if none.
    task automatic measure(input int tog_at, input bit pulse, input int maxn,
                           input bit drop, output int found);
        found = 0;
        if (drop) hold = 1'b0;
        for (int n = 1; n <= maxn; n++) begin
            @(posedge clk); #1;
            if (expire) begin found = n; break; end
            if (n == tog_at) svc = ~svc;
            if (pulse && n == tog_at + 1) svc = ~svc;
        end
    endtask

    typedef struct packed {
        logic [1:0]  code;
        logic        fl;
        logic [31:0] exp_n;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 32'd9},
        '{2'd1, 1'b0, 32'd129},
        '{2'd2, 1'b0, 32'd2033},
        '{2'd3, 1'b0, 32'd32505},
        '{2'd0, 1'b1, 32'd0},
        '{2'd1, 1'b1, 32'd0}
    };

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int got;
        int L;
        L = period_of(0);

        // R1: reset state
        repeat (4) @(posedge clk);
        #1;
        check("R1 expire in reset", int'(expire), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 expire after reset with hold", int'(expire), 0);

        // R5 / R3 / R6: vector table
        for (int i = 0; i < NVEC; i++) begin
            int win;
            rehold(int'(VECS[i].code), VECS[i].fl);
            win = (VECS[i].exp_n != 0) ? int'(VECS[i].exp_n) + 4
                                       : 4 * period_of(int'(VECS[i].code)) + 20;
            measure(0, 1'b0, win, 1'b1, got);
            check(VECS[i].fl ? "R6 float self-service" : "R5 period code",
                  got, int'(VECS[i].exp_n));
            if (VECS[i].exp_n != 0) begin
                check("R3 computed period", got, period_of(int'(VECS[i].code)) + 1);
            end
        end
        flt = 1'b0;

        // R9 and R3 repeat
        rehold(0, 1'b0);
        measure(0, 1'b0, 40, 1'b1, got);
        check("R3 first pulse", got, L + 1);
        @(posedge clk); #1;
        check("R9 pulse width one cycle", int'(expire), 0);
        measure(0, 1'b0, 40, 1'b0, got);
        check("R3 repeat pulse spacing", got, L);

        // R2: held level does not clear
        rehold(0, 1'b0);
        svc = 1'b1;
        repeat (6) @(posedge clk);
        #1;
        measure(0, 1'b0, 40, 1'b1, got);
        check("R2 held high level ignored", got, L + 1);

        // R2: falling edge clears
        rehold(0, 1'b0);
        measure(3, 1'b0, 60, 1'b1, got);
        check("R2 falling edge clears", got, 3 + 3 + L);

        // R2: rising edge clears
        rehold(0, 1'b0);
        measure(3, 1'b0, 60, 1'b1, got);
        check("R2 rising edge clears", got, 3 + 3 + L);

        // R7: event on the threshold edge wins
        rehold(0, 1'b0);
        measure(L - 2, 1'b0, 60, 1'b1, got);
        check("R7 service beats expiry", got, 2 * L + 1);

        // R7 boundary: one cycle late, expiry happens
        rehold(0, 1'b0);
        measure(L - 1, 1'b0, 60, 1'b1, got);
        check("R7 late service loses", got, L + 1);

        // R8: single-cycle pulse gives two events
        rehold(0, 1'b0);
        measure(3, 1'b1, 60, 1'b1, got);
        check("R8 one-cycle pulse", got, 3 + 4 + L);

        // R4: hold mid-count keeps output quiet, then full period
        rehold(0, 1'b0);
        measure(0, 1'b0, 5, 1'b1, got);
        check("R4 no early pulse", got, 0);
        hold = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 3 * L; k++) begin
                @(posedge clk); #1;
                if (expire) seen++;
            end
            check("R4 quiet while hold", seen, 0);
        end
        measure(0, 1'b0, 40, 1'b1, got);
        check("R4 restart from zero", got, L + 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule